// File: doc/BRIEF.md
# Combining Server Node Controller

This controller sits at a node chosen to serve one heavily shared data block on behalf of a group of client nodes. It keeps its own copy of the block, marked by a valid flag and a modified flag. A client read is answered from that copy when the copy is valid and unmodified. Otherwise the controller sends one read request toward the block's home node. Later client reads that arrive while that fetch is in flight are not sent on. They are recorded in a pending bit vector indexed by client ID, and the single returning data message answers all of them.

The home node can also push a fresh shared copy to the server. When the block is about to be written elsewhere, the home sends an invalidation. The server then drops its copy, sends an invalidation to every client that received data from it, collects their acknowledgements, and finally raises one acknowledgement toward the new owner. All message ports are valid/ready streams. An output holds its payload while ready is low. The server accepts no client reads and no further invalidation while an invalidation round is open. The data input from the home is always ready, and client acknowledgements are always taken.

Top module: `combine_server`

## Requirements
- R1: After reset, no output stream is valid, the copy is invalid, and `creq_ready` and `hinv_ready` are high.
- R2: A read that arrives while the copy is valid and unmodified, with no fetch in flight, raises `crsp_valid` for that client, carrying the held data, in the cycle after acceptance. It sends nothing toward the home.
- R3: A read that finds no valid copy causes exactly one handshake on `fwd_valid`/`fwd_ready`.
- R4: A read that finds a modified copy (with no waiting clients) is forwarded toward the home instead of being answered.
- R5: Reads accepted while a forwarded read is outstanding are combined: they add no forward handshake.
- R6: A data response (`hdat_mcast`=0) installs the copy with the modified flag taken from `hdat_mod`. The response answers every waiting client one per handshake, in ascending client ID order, with that data.
- R7: A pushed copy (`hdat_mcast`=1) installs a valid, unmodified copy, so that the next read is answered without a fetch.
- R8: An accepted invalidation clears the copy. It sends `cinv_id` once for each client that received data since the last round, in ascending ID order. `oack_valid` stays low until every one of those clients has acknowledged on `cack_valid`/`cack_id`. Meanwhile `creq_ready` and `hinv_ready` are low.
- R9: An invalidation that finds no such clients raises `oack_valid` in the cycle after acceptance and sends no client invalidation.
- R10: An invalidation accepted while a fetch is outstanding keeps the waiting clients. The data that then returns is discarded without a reply, exactly one new forward follows, and the next response answers the waiting clients.
- R11: While `crsp_ready` is low, `crsp_valid` and `crsp_id` hold, and a later read from a lower ID does not overtake them, unless an invalidation is accepted. `cinv_valid`/`cinv_id` and `oack_valid` also hold under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| creq_valid | input | 1 | Client read request valid |
| creq_ready | output | 1 | Client read request accepted |
| creq_id | input | CID_W | Requesting client ID |
| crsp_valid | output | 1 | Reply to a client valid |
| crsp_ready | input | 1 | Reply taken |
| crsp_id | output | CID_W | Client the reply goes to |
| crsp_data | output | DATA_W | Block data in the reply |
| fwd_valid | output | 1 | Read request toward the home valid |
| fwd_ready | input | 1 | Home request taken |
| hdat_valid | input | 1 | Data message from the home valid |
| hdat_ready | output | 1 | Data message taken (always high) |
| hdat_mcast | input | 1 | 1 = pushed shared copy, 0 = response to a forwarded read |
| hdat_mod | input | 1 | Response installs the copy as modified |
| hdat_data | input | DATA_W | Block data from the home |
| hinv_valid | input | 1 | Invalidation from the home valid |
| hinv_ready | output | 1 | Invalidation accepted |
| cinv_valid | output | 1 | Invalidation to a client valid |
| cinv_ready | input | 1 | Client invalidation taken |
| cinv_id | output | CID_W | Client being invalidated |
| cack_valid | input | 1 | Client acknowledgement (always taken) |
| cack_id | input | CID_W | Acknowledging client |
| oack_valid | output | 1 | Acknowledgement to the new owner valid |
| oack_ready | input | 1 | Owner acknowledgement taken |

## Verification
A cold miss followed by two more reads, arriving out of ID order, shows that combining sends one forward and that the replies are released in ascending ID order. A read to a held copy, then to a modified copy, then after a pushed copy tells a local answer apart from a fetch. Invalidation rounds are tried with four sharers and delayed acknowledgements, with no sharers, and with a fetch in flight. These separate early owner acknowledgement, a skipped client invalidation, and data that should have been dropped. A stalled reply with a lower ID arriving behind it shows whether the reply port holds its target.

// File: rtl/cns_pkg.sv
package cns_pkg;

  typedef struct packed {
    logic valid;
    logic modified;
  } line_st_t;

  typedef enum logic {
    DK_RESP  = 1'b0,
    DK_MCAST = 1'b1
  } dkind_t;

endpackage

// File: rtl/cns_pick.sv
module cns_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);

  // lowest set bit wins: scan from the top so the last hit is the smallest
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/cns_inv_relay.sv
module cns_inv_relay #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] start_set,
  output logic         active,
  output logic         cinv_valid,
  input  logic         cinv_ready,
  output logic [W-1:0] cinv_id,
  input  logic         cack_valid,
  input  logic [W-1:0] cack_id,
  output logic         oack_valid,
  input  logic         oack_ready
);

  logic [N-1:0] todo_q, wait_q, todo_grant, ack_mask;
  logic         todo_any, cinv_fire, oack_fire;

  cns_pick #(.N(N), .W(W)) u_todo_pick (
    .req  (todo_q),
    .any  (todo_any),
    .idx  (cinv_id),
    .grant(todo_grant)
  );

  always_comb begin
    for (int i = 0; i < N; i++) ack_mask[i] = cack_valid && (cack_id == W'(i));
  end

  assign cinv_valid = todo_any;
  assign cinv_fire  = cinv_valid && cinv_ready;
  assign oack_valid = active && (todo_q == '0) && (wait_q == '0);
  assign oack_fire  = oack_valid && oack_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      todo_q <= '0;
      wait_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      todo_q <= start_set;
      wait_q <= start_set;
    end else begin
      if (cinv_fire) todo_q <= todo_q & ~todo_grant;
      wait_q <= wait_q & ~ack_mask;
      if (oack_fire) active <= 1'b0;
    end
  end

  // R9: an empty sharer set acknowledges the owner right away
  a_r9_empty_round: assert property (@(posedge clk) disable iff (!rst_n)
    start && (start_set == '0) |=> oack_valid);

  // R11: client invalidations hold under back-pressure
  a_r11_cinv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cinv_valid && !cinv_ready |=> cinv_valid && $stable(cinv_id));

  // R11: owner acknowledgement holds under back-pressure
  a_r11_oack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    oack_valid && !oack_ready |=> oack_valid);

endmodule

// File: rtl/combine_server.sv
module combine_server
  import cns_pkg::*;
#(
  parameter int N_CLIENTS = 8,
  parameter int DATA_W    = 32,
  localparam int CID_W    = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              creq_valid,
  output logic              creq_ready,
  input  logic [CID_W-1:0]  creq_id,
  output logic              crsp_valid,
  input  logic              crsp_ready,
  output logic [CID_W-1:0]  crsp_id,
  output logic [DATA_W-1:0] crsp_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  input  logic              hdat_valid,
  output logic              hdat_ready,
  input  logic              hdat_mcast,
  input  logic              hdat_mod,
  input  logic [DATA_W-1:0] hdat_data,
  input  logic              hinv_valid,
  output logic              hinv_ready,
  output logic              cinv_valid,
  input  logic              cinv_ready,
  output logic [CID_W-1:0]  cinv_id,
  input  logic              cack_valid,
  input  logic [CID_W-1:0]  cack_id,
  output logic              oack_valid,
  input  logic              oack_ready
);

  line_st_t                line_q;
  logic [DATA_W-1:0]       data_q;
  logic [N_CLIENTS-1:0]    pend_q, sharers_q;
  logic                    inflight_q, need_fwd_q, drop_q, lock_q;
  logic [CID_W-1:0]        lock_id_q;

  logic                    inv_active;
  logic                    creq_fire, hinv_fire, hdat_fire, resp_fire, mc_fire;
  logic                    rsp_fire, fwd_fire, serve_ok, hit, miss_new;
  logic                    pend_any, inv_hits_fetch, need_fwd_d;
  logic [CID_W-1:0]        pick_id, sel_id;
  logic [N_CLIENTS-1:0]    pick_grant, lock_mask, sel_mask, req_mask;
  logic [N_CLIENTS-1:0]    served_mask, pend_next, sharers_plus;
  dkind_t                  hkind;

  assign creq_ready = !inv_active;
  assign hinv_ready = !inv_active;
  assign hdat_ready = 1'b1;

  assign hkind     = dkind_t'(hdat_mcast);
  assign creq_fire = creq_valid && creq_ready;
  assign hinv_fire = hinv_valid && hinv_ready;
  assign hdat_fire = hdat_valid && hdat_ready;
  assign resp_fire = hdat_fire && (hkind == DK_RESP);
  assign mc_fire   = hdat_fire && (hkind == DK_MCAST);

  always_comb begin
    for (int i = 0; i < N_CLIENTS; i++) begin
      req_mask[i]  = creq_fire && (creq_id == CID_W'(i));
      lock_mask[i] = (lock_id_q == CID_W'(i));
    end
  end

  // reply selection: lowest waiting ID, frozen while the reply is stalled
  cns_pick #(.N(N_CLIENTS), .W(CID_W)) u_rsp_pick (
    .req  (pend_q),
    .any  (pend_any),
    .idx  (pick_id),
    .grant(pick_grant)
  );

  assign sel_id   = lock_q ? lock_id_q : pick_id;
  assign sel_mask = lock_q ? lock_mask : pick_grant;

  assign serve_ok   = line_q.valid && !need_fwd_q && !inflight_q;
  assign crsp_valid = serve_ok && pend_any;
  assign crsp_id    = sel_id;
  assign crsp_data  = data_q;
  assign rsp_fire   = crsp_valid && crsp_ready;

  assign served_mask  = rsp_fire ? sel_mask : '0;
  assign pend_next    = (pend_q & ~served_mask) | req_mask;
  assign sharers_plus = sharers_q | served_mask;

  // a modified copy still being handed out also serves late arrivals
  assign hit      = line_q.valid && (!line_q.modified || pend_any);
  assign miss_new = creq_fire && !hit && !inflight_q && !need_fwd_q;

  assign fwd_valid = need_fwd_q;
  assign fwd_fire  = fwd_valid && fwd_ready;

  assign inv_hits_fetch = hinv_fire && (inflight_q || fwd_fire) && !resp_fire;

  always_comb begin
    need_fwd_d = need_fwd_q;
    if (fwd_fire) need_fwd_d = 1'b0;
    if (miss_new) need_fwd_d = 1'b1;
    if (resp_fire && drop_q && (pend_next != '0)) need_fwd_d = 1'b1;
    if (hinv_fire && !inv_hits_fetch && (pend_next != '0)) need_fwd_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q     <= '0;
      data_q     <= '0;
      pend_q     <= '0;
      sharers_q  <= '0;
      inflight_q <= 1'b0;
      need_fwd_q <= 1'b0;
      drop_q     <= 1'b0;
      lock_q     <= 1'b0;
      lock_id_q  <= '0;
    end else begin
      pend_q     <= pend_next;
      sharers_q  <= hinv_fire ? '0 : sharers_plus;
      need_fwd_q <= need_fwd_d;

      if (hinv_fire) begin
        line_q <= '0;
      end else if (mc_fire) begin
        line_q <= '{valid: 1'b1, modified: 1'b0};
        data_q <= hdat_data;
      end else if (resp_fire && !drop_q) begin
        line_q <= '{valid: 1'b1, modified: hdat_mod};
        data_q <= hdat_data;
      end

      if (fwd_fire)       inflight_q <= 1'b1;
      else if (resp_fire) inflight_q <= 1'b0;

      if (inv_hits_fetch) drop_q <= 1'b1;
      else if (resp_fire) drop_q <= 1'b0;

      if (hinv_fire || rsp_fire) begin
        lock_q <= 1'b0;
      end else if (crsp_valid && !crsp_ready) begin
        lock_q    <= 1'b1;
        lock_id_q <= sel_id;
      end
    end
  end

  cns_inv_relay #(.N(N_CLIENTS), .W(CID_W)) u_relay (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (hinv_fire),
    .start_set (sharers_plus),
    .active    (inv_active),
    .cinv_valid(cinv_valid),
    .cinv_ready(cinv_ready),
    .cinv_id   (cinv_id),
    .cack_valid(cack_valid),
    .cack_id   (cack_id),
    .oack_valid(oack_valid),
    .oack_ready(oack_ready)
  );

  // R3: a forward is not repeated while its answer is awaited
  a_r3_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_ready |=> !fwd_valid);

  // R5: reads during an outstanding fetch do not raise a new forward
  a_r5_combine: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid && creq_ready && inflight_q && !hdat_valid |=> !fwd_valid);

  // R8: once invalidated, nothing is answered from the old copy
  a_r8_inv_stops_replies: assert property (@(posedge clk) disable iff (!rst_n)
    hinv_valid && hinv_ready |=> !crsp_valid);

  // R11: a stalled reply keeps its target
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    crsp_valid && !crsp_ready && !(hinv_valid && hinv_ready)
    |=> crsp_valid && $stable(crsp_id));

endmodule

// File: tb/combine_server_test.sv
module combine_server_test;

  localparam int N  = 8;
  localparam int DW = 32;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          creq_valid = 1'b0, crsp_ready = 1'b1, fwd_ready = 1'b1;
  logic          hdat_valid = 1'b0, hdat_mcast = 1'b0, hdat_mod = 1'b0;
  logic          hinv_valid = 1'b0, cinv_ready = 1'b1, cack_valid = 1'b0;
  logic          oack_ready = 1'b1;
  logic [CW-1:0] creq_id = '0, cack_id = '0;
  logic [DW-1:0] hdat_data = '0;
  logic          creq_ready, crsp_valid, fwd_valid, hdat_ready, hinv_ready;
  logic          cinv_valid, oack_valid;
  logic [CW-1:0] crsp_id, cinv_id;
  logic [DW-1:0] crsp_data;

  int checks = 0;
  int errors = 0;
  int fwd_cnt = 0;
  int oack_cnt = 0;
  int cycles = 0;
  int exp_id[$];
  logic [DW-1:0] exp_data[$];
  int cinv_log[$];

  always #2 clk = ~clk;

  combine_server #(.N_CLIENTS(N), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_id(creq_id),
    .crsp_valid(crsp_valid), .crsp_ready(crsp_ready), .crsp_id(crsp_id), .crsp_data(crsp_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .hdat_valid(hdat_valid), .hdat_ready(hdat_ready), .hdat_mcast(hdat_mcast),
    .hdat_mod(hdat_mod), .hdat_data(hdat_data),
    .hinv_valid(hinv_valid), .hinv_ready(hinv_ready),
    .cinv_valid(cinv_valid), .cinv_ready(cinv_ready), .cinv_id(cinv_id),
    .cack_valid(cack_valid), .cack_id(cack_id),
    .oack_valid(oack_valid), .oack_ready(oack_ready)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: scoreboard of replies, plus counters of other streams
  always @(negedge clk) begin
    if (rst_n) begin
      if (crsp_valid && crsp_ready) begin
        if (exp_id.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected reply: got id %0d data %0h expected none", crsp_id, crsp_data);
        end else begin
          chk("R6", "reply id", crsp_id, exp_id.pop_front());
          chk("R6", "reply data", crsp_data, exp_data.pop_front());
        end
      end
      if (fwd_valid && fwd_ready) fwd_cnt++;
      if (oack_valid && oack_ready) oack_cnt++;
      if (cinv_valid && cinv_ready) cinv_log.push_back(int'(cinv_id));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push_exp(input int id, input logic [DW-1:0] d);
    exp_id.push_back(id);
    exp_data.push_back(d);
  endtask

  task automatic do_req(input int id);
    @(posedge clk); #1;
    creq_valid = 1'b1; creq_id = CW'(id);
    @(posedge clk); #1;
    creq_valid = 1'b0;
  endtask

  task automatic do_hdat(input logic mc, input logic md, input logic [DW-1:0] d);
    @(posedge clk); #1;
    hdat_valid = 1'b1; hdat_mcast = mc; hdat_mod = md; hdat_data = d;
    @(posedge clk); #1;
    hdat_valid = 1'b0;
  endtask

  task automatic do_inv();
    @(posedge clk); #1;
    hinv_valid = 1'b1;
    @(posedge clk); #1;
    hinv_valid = 1'b0;
  endtask

  task automatic do_ack(input int id);
    @(posedge clk); #1;
    cack_valid = 1'b1; cack_id = CW'(id);
    @(posedge clk); #1;
    cack_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 50 && exp_id.size() > 0; i++) @(posedge clk);
    idle(2);
    chk(req, "pending replies left", exp_id.size(), 0);
  endtask

  task automatic ack_all(input int a, input int b);
    do_ack(a);
    if (b >= 0) do_ack(b);
    idle(3);
  endtask

  initial begin
    int f0;
    int o0;
    idle(4); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "crsp_valid", crsp_valid, 0);
    chk("R1", "fwd_valid", fwd_valid, 0);
    chk("R1", "cinv_valid", cinv_valid, 0);
    chk("R1", "oack_valid", oack_valid, 0);
    chk("R1", "creq_ready", creq_ready, 1);
    chk("R1", "hinv_ready", hinv_ready, 1);

    // R3 cold miss, R5 combining, R6 ordered answer
    do_req(3);
    idle(2);
    chk("R3", "forwards after miss", fwd_cnt, 1);
    do_req(5);
    do_req(1);
    idle(3);
    chk("R5", "forwards while outstanding", fwd_cnt, 1);
    push_exp(1, 32'hA1A1_0001);
    push_exp(3, 32'hA1A1_0001);
    push_exp(5, 32'hA1A1_0001);
    do_hdat(1'b0, 1'b0, 32'hA1A1_0001);
    drain("R6");

    // R2 hit on valid unmodified copy
    push_exp(2, 32'hA1A1_0001);
    do_req(2);
    @(negedge clk);
    chk("R2", "reply next cycle valid", crsp_valid, 1);
    chk("R2", "reply next cycle id", crsp_id, 2);
    drain("R2");
    chk("R2", "no forward on hit", fwd_cnt, 1);

    // R8 invalidation fan-out to sharers 1,2,3,5
    cinv_log.delete();
    do_inv();
    idle(8);
    chk("R8", "client invalidations sent", cinv_log.size(), 4);
    if (cinv_log.size() == 4) begin
      chk("R8", "cinv order 0", cinv_log[0], 1);
      chk("R8", "cinv order 1", cinv_log[1], 2);
      chk("R8", "cinv order 2", cinv_log[2], 3);
      chk("R8", "cinv order 3", cinv_log[3], 5);
    end
    @(negedge clk);
    chk("R8", "oack before acks", oack_valid, 0);
    chk("R8", "creq_ready during round", creq_ready, 0);
    chk("R8", "hinv_ready during round", hinv_ready, 0);
    do_ack(1); do_ack(2); do_ack(3);
    @(negedge clk);
    chk("R8", "oack with one ack missing", oack_valid, 0);
    do_ack(5);
    @(negedge clk);
    chk("R8", "oack after last ack", oack_valid, 1);
    idle(2);
    chk("R8", "owner acks", oack_cnt, 1);

    // R8 copy gone: next read fetches; response installs modified copy
    do_req(4);
    idle(2);
    chk("R8", "read after invalidation forwards", fwd_cnt, 2);
    push_exp(4, 32'hB2B2_0002);
    do_hdat(1'b0, 1'b1, 32'hB2B2_0002);
    drain("R6");
    // R4 modified copy forces a forward
    do_req(6);
    idle(3);
    chk("R4", "forward on modified copy", fwd_cnt, 3);
    push_exp(6, 32'hC3C3_0003);
    do_hdat(1'b0, 1'b0, 32'hC3C3_0003);
    drain("R4");

    // clear sharers 4,6
    cinv_log.delete();
    do_inv();
    idle(3);
    ack_all(4, 6);
    chk("R8", "owner acks after second round", oack_cnt, 2);

    // R9 round with no sharers
    cinv_log.delete();
    do_inv();
    @(negedge clk);
    chk("R9", "immediate oack", oack_valid, 1);
    idle(3);
    chk("R9", "no client invalidation", cinv_log.size(), 0);
    chk("R9", "owner acks", oack_cnt, 3);

    // R7 pushed copy serves without a fetch
    f0 = fwd_cnt;
    do_hdat(1'b1, 1'b0, 32'hD4D4_0004);
    push_exp(0, 32'hD4D4_0004);
    do_req(0);
    drain("R7");
    chk("R7", "no forward after push", fwd_cnt, f0);

    // clear sharer 0
    do_inv();
    idle(3);
    ack_all(0, -1);

    // R10 invalidation during an outstanding fetch
    f0 = fwd_cnt;
    do_req(7);
    idle(3);
    chk("R10", "first forward", fwd_cnt, f0 + 1);
    o0 = oack_cnt;
    do_inv();
    idle(3);
    chk("R10", "owner ack with no sharers", oack_cnt, o0 + 1);
    do_hdat(1'b0, 1'b0, 32'hE5E5_0005);
    idle(4);
    chk("R10", "stale data not replied", exp_id.size(), 0);
    chk("R10", "single re-forward", fwd_cnt, f0 + 2);
    push_exp(7, 32'hF6F6_0006);
    do_hdat(1'b0, 1'b0, 32'hF6F6_0006);
    drain("R10");
    chk("R10", "no further forward", fwd_cnt, f0 + 2);

    // R11 stalled reply holds target; lower ID waits behind it
    crsp_ready = 1'b0;
    do_req(2);
    do_req(0);
    idle(3);
    @(negedge clk);
    chk("R11", "stalled reply valid", crsp_valid, 1);
    chk("R11", "stalled reply id", crsp_id, 2);
    push_exp(2, 32'hF6F6_0006);
    push_exp(0, 32'hF6F6_0006);
    @(posedge clk); #1;
    crsp_ready = 1'b1;
    drain("R11");

    finish_run();
  end

endmodule